// File: doc/BRIEF.md
# Banked Memory Paging Unit

This unit sits between an 8-bit processor with a 16-bit address bus and a memory system larger than 64KB. The address space is cut into four 16KB segments, selected by the top two address bits. Segment 0 is fixed ROM and segment 2 is fixed RAM. Segment 1 is a 16-page ROM window and segment 3 is a 16-page RAM window. The unit turns each access into an extended physical address, one chip select per 8KB ROM device, a RAM enable and a flag that marks accesses served by an expansion slot.

Four 4-bit page registers are loaded by processor I/O write cycles. One register serves DMA cycles. One serves processor writes into the RAM window and one serves processor reads from it, so data can move between two RAM pages without reprogramming anything. The fourth sets the ROM window page. The only state in the unit is these four registers. They have two conditions: cleared while power-good is low, and loaded on an I/O write hit. All address decoding is combinational from the registers and the current bus cycle.

Top module: `mem_page_unit`

## Requirements
- R1: While `rst_n` is low, all four page registers read as page 0 and I/O writes are not taken. Windowed accesses during and just after reset select page 0.
- R2: An I/O write (`io_wr` high at a clock edge) to port 20h loads the DMA page, 21h the RAM write page, 22h the RAM read page and 23h the ROM page. Only `io_data[3:0]` is stored and bits 7:4 have no effect.
- R3: I/O writes to any other port, and cycles with `io_wr` low, leave all four page registers unchanged.
- R4: Segment 0 (0000h–3FFFh) ignores every page register. `rom_cs[0]` selects 0000h–1FFFh and `rom_cs[1]` selects 2000h–3FFFh. At most one `rom_cs` bit is ever high.
- R5: In segment 1 (4000h–7FFFh), a processor access uses the ROM page p. It raises `rom_cs[2+2p]` for 4000h–5FFFh and `rom_cs[3+2p]` for 6000h–7FFFh.
- R6: In segment 3 (C000h–FFFFh), a processor read uses the RAM read page and a processor write uses the RAM write page. When the page is below 8, `ram_en` is high.
- R7: Segment 2 (8000h–BFFFh) ignores every page register and raises `ram_en` for any access. `ram_en` is only ever high in segments 2 and 3.
- R8: With `dma_cyc` high, both windows (segments 1 and 3) use the DMA page register, for reads and for writes.
- R9: A windowed access whose selected page is 8 to 15 raises `exp_flag` and holds every `rom_cs` bit and `ram_en` low.
- R10: With neither `mem_rd` nor `mem_wr` high, `rom_cs`, `ram_en` and `exp_flag` are all low.
- R11: `ext_addr` is {page, addr[13:0]} in windows and {0000b, addr[13:0]} in fixed segments. In the window, the write page applies only when `mem_wr` is high. A register loaded at a clock edge is used from that edge on. An access in the same cycle as the I/O write still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-good, low clears all page registers (asynchronous) |
| io_wr | input | 1 | I/O write cycle strobe |
| io_port | input | 8 | I/O port number |
| io_data | input | 8 | I/O write data |
| mem_rd | input | 1 | Memory read cycle |
| mem_wr | input | 1 | Memory write cycle |
| dma_cyc | input | 1 | Current memory cycle is driven by the DMA engine |
| addr | input | 16 | Logical address |
| ext_addr | output | 18 | Extended physical address {page, offset} |
| rom_cs | output | 18 | One select per 8KB ROM device: 2 fixed, then 2 per on-board page |
| ram_en | output | 1 | On-board RAM enable |
| exp_flag | output | 1 | Access served by an expansion slot (page 8–15) |

## Verification
A page-register load and a windowed memory access can fall in the same cycle. The bench provokes this by driving an I/O write to the ROM page port while a read of 4000h is on the bus. It judges the outputs just before that edge against the old page, then against the new page on the next access. A behavioural model in the bench is compared with every output on every clock. That model applies register loads only after its comparison, so it also covers read and write cycles that alternate between the read and write pages of the RAM window.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

    // Segment index = addr[15:14]; the numeric values are the decode
    typedef enum logic [1:0] {
        SEG_ROM_FIX = 2'd0,
        SEG_ROM_WIN = 2'd1,
        SEG_RAM_FIX = 2'd2,
        SEG_RAM_WIN = 2'd3
    } seg_e;

    // Page register index = port offset from the register base
    typedef enum logic [1:0] {
        PR_DMA   = 2'd0,
        PR_WRITE = 2'd1,
        PR_READ  = 2'd2,
        PR_ROM   = 2'd3
    } preg_e;

    localparam int NUM_PREGS = 4;

endpackage

// File: rtl/mpu_page_regs.sv
module mpu_page_regs
    import mpu_pkg::*;
#(
    parameter int                  PAGE_W    = 4,
    parameter int                  DATA_W    = 8,
    parameter int                  PORT_W    = 8,
    parameter logic [PORT_W-1:0]   PORT_BASE = 8'h20
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               io_wr,
    input  logic [PORT_W-1:0]                  io_port,
    input  logic [DATA_W-1:0]                  io_data,
    output logic [NUM_PREGS-1:0][PAGE_W-1:0]   page_q
);

    localparam logic [DATA_W-1:0] DATA_MASK = DATA_W'((1 << PAGE_W) - 1);

    logic [NUM_PREGS-1:0] hit;

    for (genvar g = 0; g < NUM_PREGS; g++) begin : g_preg
        assign hit[g] = io_wr && (io_port == PORT_BASE + PORT_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                page_q[g] <= '0;
            end else if (hit[g]) begin
                page_q[g] <= io_data[PAGE_W-1:0];
            end
        end

        AST_PORT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
            hit[g] |=> ({{(DATA_W-PAGE_W){1'b0}}, page_q[g]} == ($past(io_data) & DATA_MASK))); // R2

        AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !hit[g] |=> $stable(page_q[g])); // R3
    end

endmodule

// File: rtl/mpu_page_mux.sv
module mpu_page_mux
    import mpu_pkg::*;
#(
    parameter int PAGE_W = 4
) (
    input  seg_e                               seg,
    input  logic                               mem_wr,
    input  logic                               dma_cyc,
    input  logic [NUM_PREGS-1:0][PAGE_W-1:0]   page_q,
    output logic [PAGE_W-1:0]                  page,
    output logic                               paged
);

    always_comb begin
        page  = '0;
        paged = 1'b0;
        unique case (seg)
            SEG_ROM_FIX, SEG_RAM_FIX: begin
                page  = '0;
                paged = 1'b0;
            end
            SEG_ROM_WIN: begin
                paged = 1'b1;
                page  = dma_cyc ? page_q[PR_DMA] : page_q[PR_ROM];
            end
            SEG_RAM_WIN: begin
                paged = 1'b1;
                if (dma_cyc) begin
                    page = page_q[PR_DMA];
                end else if (mem_wr) begin
                    page = page_q[PR_WRITE];
                end else begin
                    page = page_q[PR_READ];
                end
            end
            default: begin
                page  = '0;
                paged = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/mpu_decode.sv
module mpu_decode
    import mpu_pkg::*;
#(
    parameter int                OFF_W      = 14,
    parameter int                PAGE_W     = 4,
    parameter int                ONBOARD    = 8,
    parameter logic [PAGE_W-1:0] FIXED_BANK = '0,
    localparam int               NROM       = 2 + 2 * ONBOARD,
    localparam int               IDX_W      = $clog2(NROM + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  seg_e                     seg,
    input  logic [OFF_W-1:0]         offset,
    input  logic [PAGE_W-1:0]        page,
    input  logic                     paged,
    input  logic                     mem_rd,
    input  logic                     mem_wr,
    output logic [PAGE_W+OFF_W-1:0]  ext_addr,
    output logic [NROM-1:0]          rom_cs,
    output logic                     ram_en,
    output logic                     exp_flag
);

    localparam int DEV_BIT = OFF_W - 1;

    logic             access;
    logic             offboard;
    logic             upper_half;
    logic             rom_hit;
    logic [IDX_W-1:0] dev_idx;

    assign access     = mem_rd || mem_wr;
    assign upper_half = seg[1];
    assign offboard   = paged && ({1'b0, page} >= (PAGE_W+1)'(ONBOARD));
    assign rom_hit    = access && !upper_half && !offboard;

    always_comb begin
        if (paged) begin
            dev_idx = IDX_W'(2) + IDX_W'({page, offset[DEV_BIT]});
        end else begin
            dev_idx = IDX_W'(offset[DEV_BIT]);
        end
    end

    for (genvar i = 0; i < NROM; i++) begin : g_rom_cs
        assign rom_cs[i] = rom_hit && (dev_idx == IDX_W'(i));
    end

    assign ram_en   = access && upper_half && !offboard;
    assign exp_flag = access && offboard;
    assign ext_addr = {(paged ? page : FIXED_BANK), offset};

    AST_ROM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rom_cs)); // R4

    AST_EXP_BLOCKS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        exp_flag |-> (rom_cs == '0 && !ram_en)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd || mem_wr) |-> (rom_cs == '0 && !ram_en && !exp_flag)); // R10

    AST_RAM_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |-> (seg == SEG_RAM_FIX || seg == SEG_RAM_WIN)); // R7

endmodule

// File: rtl/mem_page_unit.sv
module mem_page_unit
    import mpu_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int PAGE_W  = 4,
    parameter int DATA_W  = 8,
    parameter int PORT_W  = 8,
    parameter int ONBOARD = 8,
    localparam int OFF_W  = ADDR_W - 2,
    localparam int NROM   = 2 + 2 * ONBOARD
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     io_wr,
    input  logic [PORT_W-1:0]        io_port,
    input  logic [DATA_W-1:0]        io_data,
    input  logic                     mem_rd,
    input  logic                     mem_wr,
    input  logic                     dma_cyc,
    input  logic [ADDR_W-1:0]        addr,
    output logic [PAGE_W+OFF_W-1:0]  ext_addr,
    output logic [NROM-1:0]          rom_cs,
    output logic                     ram_en,
    output logic                     exp_flag
);

    logic [NUM_PREGS-1:0][PAGE_W-1:0] page_q;
    logic [PAGE_W-1:0]                page;
    logic                             paged;
    seg_e                             seg;

    assign seg = seg_e'(addr[ADDR_W-1 -: 2]);

    mpu_page_regs #(
        .PAGE_W    (PAGE_W),
        .DATA_W    (DATA_W),
        .PORT_W    (PORT_W),
        .PORT_BASE (PORT_W'(8'h20))
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_wr   (io_wr),
        .io_port (io_port),
        .io_data (io_data),
        .page_q  (page_q)
    );

    mpu_page_mux #(
        .PAGE_W (PAGE_W)
    ) u_mux (
        .seg     (seg),
        .mem_wr  (mem_wr),
        .dma_cyc (dma_cyc),
        .page_q  (page_q),
        .page    (page),
        .paged   (paged)
    );

    mpu_decode #(
        .OFF_W      (OFF_W),
        .PAGE_W     (PAGE_W),
        .ONBOARD    (ONBOARD),
        .FIXED_BANK ('0)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .seg      (seg),
        .offset   (addr[OFF_W-1:0]),
        .page     (page),
        .paged    (paged),
        .mem_rd   (mem_rd),
        .mem_wr   (mem_wr),
        .ext_addr (ext_addr),
        .rom_cs   (rom_cs),
        .ram_en   (ram_en),
        .exp_flag (exp_flag)
    );

    AST_FIXED_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[ADDR_W-2] == 1'b0) |-> (ext_addr[PAGE_W+OFF_W-1:OFF_W] == '0)); // R4

endmodule

// File: tb/test_mem_page_unit.sv
module test_mem_page_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_port = '0;
    logic [7:0]  io_data = '0;
    logic        mem_rd = 1'b0;
    logic        mem_wr = 1'b0;
    logic        dma_cyc = 1'b0;
    logic [15:0] addr = '0;
    logic [17:0] ext_addr;
    logic [17:0] rom_cs;
    logic        ram_en;
    logic        exp_flag;

    int n_chk = 0;
    int n_bad = 0;
    int pg [4] = '{0, 0, 0, 0};
    bit done = 1'b0;

    always #2 clk = ~clk;

    mem_page_unit i_mem_page_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_wr    (io_wr),
        .io_port  (io_port),
        .io_data  (io_data),
        .mem_rd   (mem_rd),
        .mem_wr   (mem_wr),
        .dma_cyc  (dma_cyc),
        .addr     (addr),
        .ext_addr (ext_addr),
        .rom_cs   (rom_cs),
        .ram_en   (ram_en),
        .exp_flag (exp_flag)
    );

    task automatic step(input string tag, input logic r, input logic iw,
                        input logic [7:0] ip, input logic [7:0] id,
                        input logic rd, input logic wr, input logic dma,
                        input logic [15:0] a);
        int seg, page, idx;
        bit paged, acc;
        logic [17:0] e_ext, e_rom;
        logic e_ram, e_exp;
        @(negedge clk);
        rst_n = r; io_wr = iw; io_port = ip; io_data = id;
        mem_rd = rd; mem_wr = wr; dma_cyc = dma; addr = a;
        #1;
        if (!r) begin
            for (int k = 0; k < 4; k++) pg[k] = 0;
        end
        seg   = int'(a) / 16384;
        paged = (seg % 2) == 1;
        page  = 0;
        if (seg == 1) page = dma ? pg[0] : pg[3];
        if (seg == 3) page = dma ? pg[0] : (wr ? pg[1] : pg[2]);
        acc   = rd || wr;
        e_ext = 18'(page * 16384 + (int'(a) % 16384));
        e_exp = acc && paged && page >= 8;
        e_ram = acc && seg >= 2 && !e_exp;
        e_rom = '0;
        if (acc && seg < 2 && !e_exp) begin
            idx = (seg == 0) ? ((int'(a) / 8192) % 2) : (2 + 2 * page + ((int'(a) / 8192) % 2));
            e_rom = 18'(1) << idx;
        end
        n_chk++;
        if (ext_addr !== e_ext || rom_cs !== e_rom || ram_en !== e_ram || exp_flag !== e_exp) begin
            n_bad++;
            $display("FAIL %s addr=%h: actual ext=%h cs=%h ram=%b exp=%b expected ext=%h cs=%h ram=%b exp=%b",
                     tag, a, ext_addr, rom_cs, ram_en, exp_flag, e_ext, e_rom, e_ram, e_exp);
        end
        if (r && iw && ip >= 8'h20 && ip <= 8'h23) pg[int'(ip) - 32] = int'(id) % 16;
    endtask

    task automatic acc(input string tag, input logic rd, input logic wr,
                       input logic dma, input logic [15:0] a);
        step(tag, 1'b1, 1'b0, 8'h00, 8'h00, rd, wr, dma, a);
    endtask

    task automatic iow(input string tag, input logic [7:0] p, input logic [7:0] d);
        step(tag, 1'b1, 1'b1, p, d, 1'b0, 1'b0, 1'b0, 16'h0000);
    endtask

    initial begin
        // R1: reset state, writes during reset not taken
        step("R1", 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 16'h4000);
        step("R1", 1'b0, 1'b1, 8'h23, 8'h05, 1'b1, 1'b0, 1'b0, 16'h6000);
        step("R1", 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 16'hC000);
        step("R1", 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 16'hE000);
        acc("R1", 1'b1, 1'b0, 1'b0, 16'h4000);
        acc("R1", 1'b0, 1'b1, 1'b0, 16'hC123);
        // R2: load with upper bits set
        iow("R2", 8'h23, 8'hA3);
        acc("R2", 1'b1, 1'b0, 1'b0, 16'h4000);
        acc("R2", 1'b1, 1'b0, 1'b0, 16'h6000);
        iow("R2", 8'h21, 8'hF5);
        acc("R2", 1'b0, 1'b1, 1'b0, 16'hC000);
        // R3: other ports and strobe low
        iow("R3", 8'h24, 8'h07);
        iow("R3", 8'h1F, 8'h06);
        step("R3", 1'b1, 1'b0, 8'h23, 8'h04, 1'b0, 1'b0, 1'b0, 16'h0000);
        acc("R3", 1'b1, 1'b0, 1'b0, 16'h5555);
        // R4: fixed ROM ignores pages
        acc("R4", 1'b1, 1'b0, 1'b0, 16'h0000);
        acc("R4", 1'b1, 1'b0, 1'b0, 16'h2000);
        acc("R4", 1'b1, 1'b0, 1'b1, 16'h3FFF);
        // R5: every on-board ROM page
        for (int p = 0; p < 8; p++) begin
            iow("R5", 8'h23, 8'(p));
            acc("R5", 1'b1, 1'b0, 1'b0, 16'h4001);
            acc("R5", 1'b1, 1'b0, 1'b0, 16'h7FFE);
        end
        // R6: read and write pages alternate
        iow("R6", 8'h21, 8'h05);
        iow("R6", 8'h22, 8'h02);
        acc("R6", 1'b1, 1'b0, 1'b0, 16'hC000);
        acc("R6", 1'b0, 1'b1, 1'b0, 16'hC123);
        acc("R6", 1'b1, 1'b0, 1'b0, 16'hFFFF);
        // R7: fixed RAM
        acc("R7", 1'b1, 1'b0, 1'b0, 16'h8000);
        acc("R7", 1'b0, 1'b1, 1'b0, 16'hBFFF);
        // R8: DMA page
        iow("R8", 8'h20, 8'h06);
        acc("R8", 1'b1, 1'b0, 1'b1, 16'h4000);
        acc("R8", 1'b0, 1'b1, 1'b1, 16'hC000);
        acc("R8", 1'b1, 1'b0, 1'b1, 16'hFFFF);
        // R9: expansion pages
        iow("R9", 8'h23, 8'h09);
        acc("R9", 1'b1, 1'b0, 1'b0, 16'h4000);
        iow("R9", 8'h22, 8'h0C);
        acc("R9", 1'b1, 1'b0, 1'b0, 16'hC000);
        iow("R9", 8'h20, 8'h0F);
        acc("R9", 1'b0, 1'b1, 1'b1, 16'h6000);
        // R10: idle cycles
        acc("R10", 1'b0, 1'b0, 1'b0, 16'h0000);
        acc("R10", 1'b0, 1'b0, 1'b1, 16'h4000);
        acc("R10", 1'b0, 1'b0, 1'b0, 16'h9000);
        // R11: load and access in the same cycle
        iow("R11", 8'h23, 8'h02);
        step("R11", 1'b1, 1'b1, 8'h23, 8'h01, 1'b1, 1'b0, 1'b0, 16'h4000);
        acc("R11", 1'b1, 1'b0, 1'b0, 16'h4000);
        // R11: sweep of pages, segments and cycle kinds
        for (int p = 0; p < 16; p++) begin
            iow("R11", 8'h20, 8'(p));
            iow("R11", 8'h21, 8'((p + 1) % 16));
            iow("R11", 8'h22, 8'((p + 2) % 16));
            iow("R11", 8'h23, 8'((p + 3) % 16));
            for (int s = 0; s < 8; s++) begin
                acc("R11", 1'b1, 1'b0, 1'b0, 16'(s * 8192 + p * 37));
                acc("R11", 1'b0, 1'b1, 1'b0, 16'(s * 8192 + 8191 - p));
                acc("R11", 1'b1, 1'b0, 1'b1, 16'(s * 8192 + p));
                acc("R11", 1'b0, 1'b1, 1'b1, 16'(s * 8192 + 4096));
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule